// File: doc/BRIEF.md
# Three-Operand Register Processor Core

This block is a small processor core with separate instruction and data spaces. It reads 16-bit instruction words, one byte at a time, from an 8K-byte instruction space. It then runs one arithmetic or logic operation on an array of eight 8-bit general-purpose registers, R0 to R7. Each instruction reads up to two source registers and writes one destination register.

The instruction set has no loads, stores, branches or interrupts. The 8K-byte data space that completes the 16K-byte map therefore has no port on this block. Each instruction takes a fixed three-cycle sequence:

1. Fetch the byte at the program counter, which holds the upper half of the word.
2. Fetch the byte at the program counter plus one, which holds the lower half.
3. Execute the operation and write the result back.

A halt input freezes the core. Debug outputs show the program counter, every register and a sticky divide-by-zero flag.

Top module: `regcore`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets the program counter to 0, every register to 0x00, the divide-by-zero flag to 0 and the sequence to its first fetch cycle.
- R2: Each instruction takes three cycles. In the first cycle the instruction address is the program counter, which supplies the upper byte. In the second cycle the address is the program counter plus one, which supplies the lower byte. In the third cycle the core executes, and the program counter grows by 2 at the edge that ends that cycle.
- R3: The 13-bit program counter is always even and wraps from 0x1FFE to 0x0000.
- R4: The instruction word is {upper byte, lower byte}. The opcode is in bits 15:12, the destination in bits 11:9, the first source in bits 8:6 and the second source in bits 5:3. Bits 2:0 have no effect.
- R5: Opcode 0 writes (first source + second source) mod 256. Opcode 1 writes (first source - second source) mod 256.
- R6: Opcode 2 writes the low 8 bits of the unsigned product. Opcode 3 writes the unsigned quotient of the first source divided by a non-zero second source.
- R7: Opcode 4 writes the bitwise AND of the two sources. Opcode 5 writes the bitwise OR. Opcode 6 writes the bitwise complement of the first source and ignores the second source field.
- R8: Opcodes 7 to 15 change no register and only advance the program counter.
- R9: Opcode 3 with a zero divisor writes 0xFF and sets the divide-by-zero flag. The flag stays set until reset.
- R10: While halt is high at a rising edge, that edge changes neither the program counter, the fetch sequence, the registers nor the flag.
- R11: When a source register is also the destination, the operation uses the value the register held before the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes fetch and write-back while high |
| imem_addr | output | 13 | Instruction-space byte address |
| imem_data | input | 8 | Byte read combinationally at imem_addr |
| dbg_pc | output | 13 | Current program counter |
| dbg_regs | output | 64 | Register i on bits [8i+7:8i] |
| div0_flag | output | 1 | Sticky divide-by-zero indication |

## Verification
The assertions assume that the instruction byte is available in the same cycle as its address, because the core latches imem_data at the edge that ends each fetch cycle. They also assume that halt and rst are steady around each rising edge. The bench models the instruction space as a combinational array indexed by imem_addr. It changes halt and rst only one nanosecond after an edge, so every edge sees clean levels. The generated program uses all 16 opcodes, random register fields and random values in bits 2:0, and it runs until the program counter wraps.

// File: rtl/regcore.sv
module regcore #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int AW   = 13
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               halt,
  output logic [AW-1:0]      imem_addr,
  input  logic [7:0]         imem_data,
  output logic [AW-1:0]      dbg_pc,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic               div0_flag
);
  localparam int RW = $clog2(NREG);

  typedef enum logic [1:0] {PH_HI, PH_LO, PH_EX} phase_t;

  phase_t         ph;
  logic [AW-1:0]  pc;
  logic [7:0]     ir_hi;
  logic [4:0]     ir_lo;
  logic [DW-1:0]  rf [NREG];
  logic [DW-1:0]  res;
  logic           wr, dz;

  wire [12:0]    iw  = {ir_hi, ir_lo};
  wire [3:0]     op  = iw[12:9];
  wire [RW-1:0]  rd  = iw[8:6];
  wire [RW-1:0]  rs1 = iw[5:3];
  wire [RW-1:0]  rs2 = iw[2:0];
  wire [DW-1:0]  a   = rf[rs1];
  wire [DW-1:0]  b   = rf[rs2];
  wire           exec = (ph == PH_EX) && !halt;

  assign imem_addr = (ph == PH_LO) ? (pc | AW'(1)) : pc;
  assign dbg_pc    = pc;

  for (genvar i = 0; i < NREG; i++) begin : g_dbg
    assign dbg_regs[i*DW +: DW] = rf[i];
  end

  always_comb begin
    res = '0;
    wr  = 1'b0;
    dz  = 1'b0;
    case (op)
      4'd0: begin res = a + b; wr = 1'b1; end
      4'd1: begin res = a - b; wr = 1'b1; end
      4'd2: begin res = a * b; wr = 1'b1; end
      4'd3: begin
        wr = 1'b1;
        if (b == '0) begin res = '1; dz = 1'b1; end
        else res = a / b;
      end
      4'd4: begin res = a & b; wr = 1'b1; end
      4'd5: begin res = a | b; wr = 1'b1; end
      4'd6: begin res = ~a;    wr = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      ph        <= PH_HI;
      ir_hi     <= '0;
      ir_lo     <= '0;
      div0_flag <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!halt) begin
      case (ph)
        PH_HI: begin ir_hi <= imem_data;      ph <= PH_LO; end
        PH_LO: begin ir_lo <= imem_data[7:3]; ph <= PH_EX; end
        default: begin
          pc <= pc + AW'(2);
          ph <= PH_HI;
          if (wr) rf[rd] <= res;
          if (dz) div0_flag <= 1'b1;
        end
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0 && ph == PH_HI && !div0_flag && dbg_regs == '0));

  a_r2_fetch_order: assert property (@(posedge clk) disable iff (rst)
    (!rst && !halt && ph == PH_HI) |=> (ph == PH_LO && imem_addr == (pc | AW'(1))));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && exec) |=> (pc == $past(pc) + AW'(2) && ph == PH_HI));

  a_r3_pc_even: assert property (@(posedge clk) disable iff (rst)
    pc[0] == 1'b0);

  a_r8_nop_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (!rst && exec && op > 4'd6) |=> $stable(dbg_regs));

  a_r9_div0_sets: assert property (@(posedge clk) disable iff (rst)
    (!rst && exec && op == 4'd3 && b == '0) |=> (div0_flag && rf[$past(rd)] == '1));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rst && div0_flag) |=> div0_flag);

  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (!rst && halt) |=> ($stable(pc) && $stable(ph) && $stable(dbg_regs) && $stable(div0_flag)));
endmodule

// File: tb/regcore_tb.sv
`timescale 1ns/1ps
module regcore_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic [12:0] imem_addr;
  logic [7:0]  imem_data;
  logic [12:0] dbg_pc;
  logic [63:0] dbg_regs;
  logic        div0_flag;

  logic [7:0] mem [8192];
  int checks = 0, failures = 0;

  int m_r [8];
  int m_pc, m_ph, m_flag, m_hi, m_lo;

  always #2 clk = ~clk;
  assign imem_data = mem[imem_addr];

  regcore u_dut (.clk(clk), .rst(rst), .halt(halt), .imem_addr(imem_addr),
                 .imem_data(imem_data), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs),
                 .div0_flag(div0_flag));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int reg_of(input int i);
    return int'(dbg_regs[i*8 +: 8]);
  endfunction

  task automatic model_step();
    int op, rd, s1, s2, a, b, w;
    if (rst) begin
      for (int i = 0; i < 8; i++) m_r[i] = 0;
      m_pc = 0; m_ph = 0; m_flag = 0;
    end else if (!halt) begin
      if (m_ph == 0) begin m_hi = mem[m_pc]; m_ph = 1; end
      else if (m_ph == 1) begin m_lo = mem[m_pc + 1]; m_ph = 2; end
      else begin
        w  = (m_hi << 8) | m_lo;
        op = (w >> 12) & 15; rd = (w >> 9) & 7;
        s1 = (w >> 6) & 7;   s2 = (w >> 3) & 7;
        a = m_r[s1]; b = m_r[s2];
        case (op)
          0: m_r[rd] = (a + b) & 255;
          1: m_r[rd] = (a - b) & 255;
          2: m_r[rd] = (a * b) & 255;
          3: if (b == 0) begin m_r[rd] = 255; m_flag = 1; end
             else m_r[rd] = a / b;
          4: m_r[rd] = a & b;
          5: m_r[rd] = a | b;
          6: m_r[rd] = (~a) & 255;
          default: ;
        endcase
        m_pc = (m_pc + 2) % 8192;
        m_ph = 0;
      end
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 pc", int'(dbg_pc), m_pc);
    chk("R2 fetch address", int'(imem_addr), (m_ph == 1) ? m_pc + 1 : m_pc);
    chk("R9 flag", int'(div0_flag), m_flag);
    for (int i = 0; i < 8; i++) chk("R4/R5/R6/R7 register", reg_of(i), m_r[i]);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
  endtask

  task automatic put(input int addr, input int word);
    mem[addr]     = 8'(word >> 8);
    mem[addr + 1] = 8'(word);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, pc_snap;
    logic [63:0] regs_snap;
    seed = 17;
    for (int i = 0; i < 8192; i += 2) put(i, $urandom(seed) & 16'hFFFF);
    put(0,  16'h6000);
    put(2,  16'h1280);
    put(4,  16'h0448);
    put(6,  16'h3610);
    put(8,  16'h3828);
    put(10, 16'h2A00);
    put(12, 16'h4C18);
    put(14, 16'h5E50);
    put(16, 16'h000F);
    put(18, 16'h9E00);
    put(20, 16'h1410);
    for (int i = 0; i < 8; i++) m_r[i] = 0;

    repeat (3) tick();
    chk("R1 reset pc", int'(dbg_pc), 0);
    chk("R1 reset regs", int'(dbg_regs != 64'd0), 0);
    chk("R1 reset flag", int'(div0_flag), 0);
    rst = 1'b0;

    chk("R2 first address upper byte", int'(imem_addr), 0);
    tick();
    chk("R2 second address lower byte", int'(imem_addr), 1);
    tick();
    tick();
    chk("R2 pc after one instruction", int'(dbg_pc), 2);
    chk("R7 NOT R0", reg_of(0), 8'hFF);

    repeat (24) tick();
    chk("R5 SUB wraps to 0x01", reg_of(1), 8'h01);
    chk("R6 DIV quotient 0xFF/2", reg_of(3), 8'h7F);
    chk("R9 DIV by zero writes 0xFF", reg_of(4), 8'hFF);
    chk("R9 flag set", int'(div0_flag), 1);
    chk("R6 MUL low byte of 0xFE01", reg_of(5), 8'h01);
    chk("R7 AND", reg_of(6), 8'h7F);
    chk("R11 ADD R0,R0,R1 old value wraps to 0, R4 low bits ignored", reg_of(0), 8'h00);

    regs_snap = dbg_regs;
    repeat (3) tick();
    chk("R8 opcode 9 leaves registers", int'(dbg_regs == regs_snap), 1);
    chk("R7 OR", reg_of(7), 8'h03);
    repeat (3) tick();
    chk("R5 SUB 0-2 wraps to 0xFE", reg_of(2), 8'hFE);
    chk("R2 pc after eleven instructions", int'(dbg_pc), 22);

    tick();
    halt = 1'b1;
    pc_snap = int'(dbg_pc);
    regs_snap = dbg_regs;
    repeat (7) tick();
    chk("R10 halt holds pc", int'(dbg_pc), pc_snap);
    chk("R10 halt holds regs", int'(dbg_regs == regs_snap), 1);
    chk("R10 halt holds fetch address", int'(imem_addr), pc_snap + 1);
    halt = 1'b0;

    while (m_pc != 13'h1FFE) tick();
    chk("R3 pc reaches 0x1FFE", int'(dbg_pc), 13'h1FFE);
    repeat (3) tick();
    chk("R3 pc wraps to zero", int'(dbg_pc), 0);
    chk("R9 flag still set before reset", int'(div0_flag), 1);

    repeat (40) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid-run reset pc", int'(dbg_pc), 0);
    chk("R1 mid-run reset regs", int'(dbg_regs != 64'd0), 0);
    chk("R9 flag cleared only by reset", int'(div0_flag), 0);
    repeat (30) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule